// File: doc/BRIEF.md
# Content-Protection Transmitter Control Register

This block is the 8-bit control register that steers content protection in a serial video link transmitter. A controller writes it one byte at a time over a simple register bus. The block converts each write into the effects that the individual bits call for. Some bits give one-cycle command pulses to the authentication engine: reset, enable/restart, disable and key-list accepted. Some bits are held as levels: the receiver-key-accepted flag, the authentication-enabled status and the encryption enable. The read value shows live status where a bit has status, and 0 for command and reserved bits.

The block also picks the video output mode. It combines the encryption enable with the authenticated status input and an always-encrypt mode input. The result is encrypted video, a blue screen, or plain video. The authentication engine, the cipher and the address decoding sit outside this block.

Top module: `cp_tx_ctrl_reg`

## Requirements
- R1: While reset is asserted, and after it, every pulse output and every level output is 0. With the always-encrypt input low, the read value is 0x00 and the video mode is plain (2'b00).
- R2: Writing 1 to bit 7 (reset), bit 5 (key list accepted), bit 3 (encrypt off) or bit 1 (auth disable) raises the matching pulse output for exactly the one cycle after the write edge. These four bits always read as 0.
- R3: Writing 1 to bit 0 sets the authentication-enabled status and raises the enable/restart pulse for one cycle, even if the status is already set. Writing 0 to bit 0 leaves the status unchanged. Read bit 0 returns the status.
- R4: Writing 1 to bit 1 clears the authentication-enabled status. If bit 1 or bit 7 is written together with bit 0, the status is cleared and no enable/restart pulse is produced.
- R5: Writing 1 to bit 7 clears both the authentication-enabled status and the receiver-key-accepted flag.
- R6: Writing 1 to bit 4 sets the receiver-key-accepted flag, and writing 0 to bit 4 leaves it unchanged. A key-ready event input clears the flag at the next edge, and the clear wins over a write in the same cycle. Read bit 4 returns the flag.
- R7: When always-encrypt is low, a write stores bit 2 as the encryption enable. If bit 3 is also 1, the stored enable becomes 0 instead.
- R8: When always-encrypt is high, read bit 2 and the effective encryption output are 1, and writes do not change the stored enable. That stored value shows again once the mode input drops.
- R9: The video mode is 2'b10 (encrypted) when encryption is effective and the link is authenticated. It is 2'b01 (blue screen) when encryption is effective and the link is not authenticated. It is 2'b00 (plain) when encryption is not effective. The mode follows its inputs in the same cycle.
- R10: Bit 6 is reserved. It reads as 0, and writing it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read value (live status bits, 0 elsewhere) |
| sts_authed | input | 1 | Link is authenticated |
| sts_key_ready | input | 1 | Key-ready event from the authentication engine |
| mode_enc_always | input | 1 | Always-encrypt mode |
| o_rst_pulse | output | 1 | Transmitter reset command pulse |
| o_auth_en_pulse | output | 1 | Authentication enable/restart pulse |
| o_auth_dis_pulse | output | 1 | Authentication disable pulse |
| o_list_ok_pulse | output | 1 | Repeater key list accepted pulse |
| o_enc_dis_pulse | output | 1 | Encrypt-off command pulse |
| o_key_ok | output | 1 | Receiver key accepted flag |
| o_auth_on | output | 1 | Authentication enabled status |
| o_enc_on | output | 1 | Effective encryption enable |
| o_video_mode | output | 2 | 00 plain, 01 blue screen, 10 encrypted |

## Verification
Every pulse and stored bit is registered once, so it changes on the edge that samples the write and is due in the cycle after. The read value and the video mode are combinational: they follow the stored state after that edge, and they follow the status and mode inputs in the same cycle. The bench drives inputs just after the falling edge and compares every output against its behavioural model just before it drives the next inputs. Each result is therefore checked exactly once per cycle, at the point where its expected value is settled.

// File: rtl/cp_ctrl_pkg.sv
package cp_ctrl_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_DIS  = 1;
  localparam int unsigned B_ENC  = 2;
  localparam int unsigned B_EOFF = 3;
  localparam int unsigned B_KEY  = 4;
  localparam int unsigned B_LIST = 5;
  localparam int unsigned B_RST  = 7;
  localparam int unsigned N_CMD  = 5;
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_DIS  = 1;
  localparam int unsigned C_EOFF = 2;
  localparam int unsigned C_LIST = 3;
  localparam int unsigned C_RST  = 4;

  typedef enum logic [1:0] {
    VM_PLAIN = 2'b00,
    VM_BLUE  = 2'b01,
    VM_ENC   = 2'b10
  } vmode_e;
endpackage

// File: rtl/cp_cmd_pulse.sv
module cp_cmd_pulse #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] pulse
);
  logic [N-1:0] pulse_q;
  logic [N-1:0] pulse_d;

  for (genvar g = 0; g < N; g++) begin : g_cmd
    always_comb begin
      pulse_d[g] = req[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q[g] <= 1'b0;
      end else begin
        pulse_q[g] <= pulse_d[g];
      end
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/cp_state_bits.sv
module cp_state_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic auth_set,
  input  logic auth_clr,
  input  logic key_set,
  input  logic key_clr,
  input  logic enc_load,
  input  logic enc_val,
  output logic auth_on,
  output logic key_ok,
  output logic enc_stored
);
  logic auth_q, auth_d, auth_ce;
  logic key_q, key_d, key_ce;
  logic enc_q, enc_d, enc_ce;

  always_comb begin
    auth_ce = auth_set | auth_clr;
    auth_d  = auth_clr ? 1'b0 : 1'b1;
    key_ce  = key_set | key_clr;
    key_d   = key_clr ? 1'b0 : 1'b1;
    enc_ce  = enc_load;
    enc_d   = enc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auth_q <= 1'b0;
      key_q  <= 1'b0;
      enc_q  <= 1'b0;
    end else begin
      if (auth_ce) auth_q <= auth_d;
      if (key_ce)  key_q  <= key_d;
      if (enc_ce)  enc_q  <= enc_d;
    end
  end

  assign auth_on    = auth_q;
  assign key_ok     = key_q;
  assign enc_stored = enc_q;
endmodule

// File: rtl/cp_vmode_sel.sv
module cp_vmode_sel
  import cp_ctrl_pkg::*;
(
  input  logic   enc_on,
  input  logic   authed,
  output vmode_e mode
);
  always_comb begin
    if (!enc_on)     mode = VM_PLAIN;
    else if (authed) mode = VM_ENC;
    else             mode = VM_BLUE;
  end
endmodule

// File: rtl/cp_tx_ctrl_reg.sv
module cp_tx_ctrl_reg
  import cp_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sts_authed,
  input  logic             sts_key_ready,
  input  logic             mode_enc_always,
  output logic             o_rst_pulse,
  output logic             o_auth_en_pulse,
  output logic             o_auth_dis_pulse,
  output logic             o_list_ok_pulse,
  output logic             o_enc_dis_pulse,
  output logic             o_key_ok,
  output logic             o_auth_on,
  output logic             o_enc_on,
  output logic [1:0]       o_video_mode
);
  logic [N_CMD-1:0] cmd_req;
  logic [N_CMD-1:0] cmd_pulse;
  logic             kill_auth;
  logic             auth_on, key_ok, enc_stored, enc_eff;
  logic             enc_load, enc_val;
  vmode_e           vmode;

  always_comb begin
    kill_auth       = wr_en & (wr_data[B_DIS] | wr_data[B_RST]);
    cmd_req         = '0;
    cmd_req[C_EN]   = wr_en & wr_data[B_EN] & ~kill_auth;
    cmd_req[C_DIS]  = wr_en & wr_data[B_DIS];
    cmd_req[C_EOFF] = wr_en & wr_data[B_EOFF];
    cmd_req[C_LIST] = wr_en & wr_data[B_LIST];
    cmd_req[C_RST]  = wr_en & wr_data[B_RST];
    enc_load        = wr_en & ~mode_enc_always;
    enc_val         = wr_data[B_ENC] & ~wr_data[B_EOFF];
  end

  cp_cmd_pulse #(.N(N_CMD)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cmd_req),
    .pulse (cmd_pulse)
  );

  cp_state_bits u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .auth_set   (wr_en & wr_data[B_EN]),
    .auth_clr   (kill_auth),
    .key_set    (wr_en & wr_data[B_KEY]),
    .key_clr    (sts_key_ready | (wr_en & wr_data[B_RST])),
    .enc_load   (enc_load),
    .enc_val    (enc_val),
    .auth_on    (auth_on),
    .key_ok     (key_ok),
    .enc_stored (enc_stored)
  );

  assign enc_eff = enc_stored | mode_enc_always;

  cp_vmode_sel u_vsel (
    .enc_on (enc_eff),
    .authed (sts_authed),
    .mode   (vmode)
  );

  always_comb begin
    rd_data        = '0;
    rd_data[B_EN]  = auth_on;
    rd_data[B_ENC] = enc_eff;
    rd_data[B_KEY] = key_ok;
  end

  assign o_rst_pulse      = cmd_pulse[C_RST];
  assign o_auth_en_pulse  = cmd_pulse[C_EN];
  assign o_auth_dis_pulse = cmd_pulse[C_DIS];
  assign o_list_ok_pulse  = cmd_pulse[C_LIST];
  assign o_enc_dis_pulse  = cmd_pulse[C_EOFF];
  assign o_key_ok         = key_ok;
  assign o_auth_on        = auth_on;
  assign o_enc_on         = enc_eff;
  assign o_video_mode     = vmode;
endmodule

// File: rtl/cp_tx_ctrl_reg_chk.sv
module cp_tx_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sts_authed,
  input logic       sts_key_ready,
  input logic       mode_enc_always,
  input logic       o_rst_pulse,
  input logic       o_auth_en_pulse,
  input logic       o_auth_dis_pulse,
  input logic       o_key_ok,
  input logic       o_auth_on,
  input logic       o_enc_on,
  input logic [1:0] o_video_mode
);
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    o_rst_pulse == $past(wr_en && wr_data[7])); // R2
  AST_DIS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    o_auth_dis_pulse |-> !o_auth_en_pulse); // R4
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !wr_data[1] && !wr_data[7]) |=> (o_auth_on && o_auth_en_pulse)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_auth_on && !(wr_en && (wr_data[1] || wr_data[7]))) |=> o_auth_on); // R3
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> (!o_auth_on && !o_key_ok)); // R5
  AST_KEY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    sts_key_ready |=> !o_key_ok); // R6
  AST_ALWAYS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_enc_always |-> (rd_data[2] && o_enc_on)); // R8
  AST_VMODE: assert property (@(posedge clk) disable iff (!rst_n)
    o_video_mode == (o_enc_on ? (sts_authed ? 2'b10 : 2'b01) : 2'b00)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:5] == 3'b000) && !rd_data[3] && !rd_data[1]); // R10
endmodule

bind cp_tx_ctrl_reg cp_tx_ctrl_reg_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_en            (wr_en),
  .wr_data          (wr_data),
  .rd_data          (rd_data),
  .sts_authed       (sts_authed),
  .sts_key_ready    (sts_key_ready),
  .mode_enc_always  (mode_enc_always),
  .o_rst_pulse      (o_rst_pulse),
  .o_auth_en_pulse  (o_auth_en_pulse),
  .o_auth_dis_pulse (o_auth_dis_pulse),
  .o_key_ok         (o_key_ok),
  .o_auth_on        (o_auth_on),
  .o_enc_on         (o_enc_on),
  .o_video_mode     (o_video_mode)
);

// File: tb/cp_tx_ctrl_reg_tb.sv
module cp_tx_ctrl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sts_authed = 1'b0;
  logic       sts_key_ready = 1'b0;
  logic       mode_enc_always = 1'b0;
  logic [7:0] rd_data;
  logic       o_rst_pulse, o_auth_en_pulse, o_auth_dis_pulse, o_list_ok_pulse, o_enc_dis_pulse;
  logic       o_key_ok, o_auth_on, o_enc_on;
  logic [1:0] o_video_mode;

  integer n_chk = 0;
  integer n_fail = 0;

  always #4 clk = ~clk;

  cp_tx_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sts_authed(sts_authed), .sts_key_ready(sts_key_ready), .mode_enc_always(mode_enc_always),
    .o_rst_pulse(o_rst_pulse), .o_auth_en_pulse(o_auth_en_pulse),
    .o_auth_dis_pulse(o_auth_dis_pulse), .o_list_ok_pulse(o_list_ok_pulse),
    .o_enc_dis_pulse(o_enc_dis_pulse), .o_key_ok(o_key_ok), .o_auth_on(o_auth_on),
    .o_enc_on(o_enc_on), .o_video_mode(o_video_mode)
  );

  // behavioural reference model
  integer m_auth, m_key, m_enc;
  integer m_prst, m_pen, m_pdis, m_plist, m_peoff;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_auth <= 0; m_key <= 0; m_enc <= 0;
      m_prst <= 0; m_pen <= 0; m_pdis <= 0; m_plist <= 0; m_peoff <= 0;
    end else begin
      m_prst  <= (wr_en && wr_data[7]) ? 1 : 0;
      m_plist <= (wr_en && wr_data[5]) ? 1 : 0;
      m_peoff <= (wr_en && wr_data[3]) ? 1 : 0;
      m_pdis  <= (wr_en && wr_data[1]) ? 1 : 0;
      m_pen   <= (wr_en && wr_data[0] && !wr_data[1] && !wr_data[7]) ? 1 : 0;
      if (wr_en && (wr_data[1] || wr_data[7])) m_auth <= 0;
      else if (wr_en && wr_data[0]) m_auth <= 1;
      if (sts_key_ready || (wr_en && wr_data[7])) m_key <= 0;
      else if (wr_en && wr_data[4]) m_key <= 1;
      if (wr_en && !mode_enc_always) m_enc <= (wr_data[2] && !wr_data[3]) ? 1 : 0;
    end
  end

  task automatic check(input string tag, input integer act, input integer exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    integer e_enc, e_rd, e_vm;
    e_enc = (m_enc != 0 || mode_enc_always) ? 1 : 0;
    e_rd  = m_auth + 4 * e_enc + 16 * m_key;
    e_vm  = (e_enc == 0) ? 0 : (sts_authed ? 2 : 1);
    check("R2 cmd pulses", {o_rst_pulse, o_list_ok_pulse, o_enc_dis_pulse, o_auth_dis_pulse},
          m_prst * 8 + m_plist * 4 + m_peoff * 2 + m_pdis);
    check("R3 enable pulse", o_auth_en_pulse, m_pen);
    check("R4 auth status", o_auth_on, m_auth);
    check("R6 key flag", o_key_ok, m_key);
    check("R7 enc level", o_enc_on, e_enc);
    check("R8/R10 read value", rd_data, e_rd);
    check("R9 video mode", o_video_mode, e_vm);
  endtask

  // one cycle: compare at falling edge, then drive the next inputs
  task automatic step(input logic w, input logic [7:0] d, input logic au,
                      input logic kr, input logic al);
    @(negedge clk);
    compare_all();
    wr_en = w; wr_data = d; sts_authed = au; sts_key_ready = kr; mode_enc_always = al;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d, sts_authed, 1'b0, mode_enc_always);
    step(1'b0, 8'h00, sts_authed, 1'b0, mode_enc_always);
  endtask

  initial begin
    integer lfsr;
    repeat (3) @(negedge clk);
    check("R1 reset read", rd_data, 0);
    check("R1 reset outputs", {o_rst_pulse, o_auth_en_pulse, o_auth_dis_pulse, o_list_ok_pulse,
          o_enc_dis_pulse, o_key_ok, o_auth_on, o_enc_on, o_video_mode}, 0);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R1 after release", rd_data, 0);

    wr(8'h01);                                  // R3 enable
    check("R3 enabled read", rd_data[0], 1);
    wr(8'h00);                                  // R3 zero write ignored
    check("R3 zero no effect", o_auth_on, 1);
    step(1'b1, 8'h01, 1'b0, 1'b0, 1'b0);         // R3 restart pulse
    @(negedge clk);
    check("R3 restart pulse", o_auth_en_pulse, 1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    wr(8'h02);                                  // R4 disable
    check("R4 disabled", o_auth_on, 0);
    wr(8'h01);
    step(1'b1, 8'h03, 1'b0, 1'b0, 1'b0);         // R4 disable beats enable
    @(negedge clk);
    check("R4 no enable pulse", o_auth_en_pulse, 0);
    check("R4 status cleared", o_auth_on, 0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

    wr(8'h10);                                  // R6 key set
    check("R6 key set", rd_data[4], 1);
    wr(8'h00);
    check("R6 zero no effect", o_key_ok, 1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);         // R6 key-ready event
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 key cleared by event", o_key_ok, 0);
    step(1'b1, 8'h10, 1'b0, 1'b1, 1'b0);         // R6 event wins over write
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 event priority", o_key_ok, 0);

    wr(8'h11);
    wr(8'h80);                                  // R5 reset command
    check("R5 reset clears", {o_auth_on, o_key_ok}, 0);
    wr(8'h20);                                  // R2 list pulse
    wr(8'h40);                                  // R10 reserved
    check("R10 reserved read", rd_data, 0);

    wr(8'h04);                                  // R7, R9 blue screen
    check("R9 blue screen", o_video_mode, 1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R9 encrypted", o_video_mode, 2);
    wr(8'h0C);                                  // R7 encrypt-off wins
    check("R7 encrypt off", o_enc_on, 0);
    wr(8'h04);
    wr(8'h08);
    check("R7 encrypt off alone", o_enc_on, 0);

    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);         // R8 always mode
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R8 forced read", rd_data[2], 1);
    wr(8'h04);
    wr(8'h08);
    check("R8 write ignored", o_enc_on, 1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R8 stored value kept", o_enc_on, 0);

    lfsr = 32'h1ACE5;
    for (int i = 0; i < 2000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      step(lfsr[0], lfsr[15:8], lfsr[16], lfsr[20] & lfsr[21], lfsr[24] & lfsr[25]);
    end
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule